// File: doc/BRIEF.md
# Grouped Match-Timer Bank

The block holds eight match-timer channels, numbered 4 to 11 in software terms (local index 0 to 7 inside the RTL). Each channel has a counter, a match value and a control word. The control word chooses which of five tick-enable inputs advances the counter. It also chooses whether the channel keeps its own counter or follows the counter of its group leader, whether a match clears the counter, and whether the channel keeps matching after the first event. Tick enables arrive as single-cycle pulses that are generated elsewhere. The block itself contains no prescaler.

Every channel match can set a status bit once that channel's enable bit is on. Software clears a status bit by writing a one to it. One interrupt output stays high while any status bit is set. The two odd channels of the wide group can, on a read of their counter, freeze the value of the neighbouring even counter into a snapshot register. Software can then read the snapshot at leisure.

Access is a simple register port. A write takes effect at the clock edge that samples it. A read returns data on the cycle after the read strobe, and that data holds until the next read.

Top module: `ext_timer_bank`

## Requirements
- R1: After reset, every counter, match, control, status, enable and snapshot register reads as zero, `rdata_o` is zero and `irq_o` is low.
- R2: Control bits [2:0] pick the tick: 1 selects `tick_i[0]`, 2 `tick_i[1]`, 3 `tick_i[2]`, 4 `tick_i[3]` and 5 `tick_i[4]`. Values 0, 6 and 7 give no tick. A counter that gets no tick and no write keeps its value.
- R3: While control bit 7 is clear, channels 5, 6 and 7 use channel 4's counter, channel 9 uses channel 8's and channel 11 uses channel 10's. Channels 4, 8 and 10, and any channel with bit 7 set, use their own counter. A channel that uses a leader's counter does not advance its own counter.
- R4: A channel is armed by a write to its match or control register. An armed channel matches when the counter it uses takes a tick and the incremented value equals its match value.
- R5: With control bit 3 set, a match on a channel that counts on its own counter loads zero into that counter instead of the incremented value.
- R6: With control bit 6 set, a channel stays armed after a match. With bit 6 clear, the match disarms it, and later passes over the match value produce no event.
- R7: Channels 4 to 7 keep only control bits [7:0], and channels 8 to 11 keep bits [9:0]. On channels 8 to 11, bit 8 set stops the channel's own counter.
- R8: A read of the counter of channel 9 or 11 whose control bit 9 is set copies the current counter of channel 8 or 10 into the snapshot register at offset 0x20. No other action changes the snapshot.
- R9: At offset 0x14, status bits 4 to 11 belong to channels 4 to 11. A match sets a bit only when the same bit of the enable register at 0x1C is set. Writing a one to a status bit clears it.
- R10: `irq_o` is high while any status bit is set and falls only once all of them are clear.
- R11: A counter write is visible on the next cycle. It takes priority over a tick or a zero-on-match in the same cycle, and it works while the channel is stopped.
- R12: Counters sit at 0x40, match registers at 0x80 and control words at 0xC0, each with a 4-byte stride ordered by channel. Read data appears the cycle after `rd_en_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | ADDR_W | Byte offset of the register |
| wdata_i | input | DATA_W | Write data |
| tick_i | input | 5 | Tick-enable pulses, one per selectable rate |
| rdata_o | output | DATA_W | Read data, registered |
| irq_o | output | 1 | Combined channel interrupt |

## Verification
The main counting path is driven with pulses on the selected tick and on tick inputs that were not selected. A counter that moves only on its own rate shows the selection is correct. The same tick stream is then run through a leader and a follower, and then through a channel that has taken its own counter back. This separates a shared count from a private one. Match behaviour is tried with reset-on-match combined with periodic mode and with one-shot mode, and the counter values after several passes tell the two apart. Snapshot, interrupt-enable gating and write-versus-tick collisions each get a directed sequence, in which the register that must not change is read back afterwards.

// File: rtl/ext_tmr_pkg.sv
package ext_tmr_pkg;
    localparam int unsigned NCH       = 8;   // channels in the bank
    localparam int unsigned CTL_W     = 10;  // widest control word
    localparam int unsigned NTICK     = 5;   // selectable tick inputs
    localparam int unsigned FIRST_CH  = 4;   // status bit of local channel 0
    localparam int unsigned WIDE_BASE = 4;   // first local index with a wide control word
    localparam int unsigned NARROW_W  = 8;

    // control bit positions
    localparam int unsigned CB_ZERO   = 3;
    localparam int unsigned CB_REPEAT = 6;
    localparam int unsigned CB_OWN    = 7;
    localparam int unsigned CB_HALT   = 8;
    localparam int unsigned CB_SNAP   = 9;

    // register offsets and region tags (addr[7:5])
    localparam logic [7:0] A_STAT  = 8'h14;
    localparam logic [7:0] A_ENA   = 8'h1C;
    localparam logic [7:0] A_SNAP  = 8'h20;
    localparam logic [2:0] RG_CNT  = 3'b010;
    localparam logic [2:0] RG_MAT  = 3'b100;
    localparam logic [2:0] RG_CTL  = 3'b110;

    // Which local channel's counter a channel counts on.
    function automatic logic [2:0] lead_of(input logic [2:0] n, input logic own);
        logic [2:0] r;
        r = n;
        if (!own) begin
            if (n < 3'd4)       r = 3'd0;
            else if (n == 3'd5) r = 3'd4;
            else if (n == 3'd7) r = 3'd6;
        end
        return r;
    endfunction
endpackage

// File: rtl/ext_tmr_tick_mux.sv
module ext_tmr_tick_mux
    import ext_tmr_pkg::*;
(
    input  logic [2:0]       sel_i,
    input  logic             halt_i,
    input  logic [NTICK-1:0] tick_i,
    output logic             step_o
);
    always_comb begin
        step_o = 1'b0;
        if (!halt_i && sel_i != 3'd0 && sel_i <= 3'(NTICK)) begin
            step_o = tick_i[sel_i - 3'd1];
        end
    end
endmodule

// File: rtl/ext_tmr_cmp.sv
module ext_tmr_cmp #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             armed_i,
    input  logic             step_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [CNT_W-1:0] mat_i,
    output logic             hit_o
);
    logic [CNT_W-1:0] next_val;
    assign next_val = cnt_i + 1'b1;
    assign hit_o    = armed_i && step_i && (next_val == mat_i);
endmodule

// File: rtl/ext_timer_bank.sv
module ext_timer_bank
    import ext_tmr_pkg::*;
#(
    parameter int unsigned CNT_W  = 32,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [NTICK-1:0]  tick_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              irq_o
);
    localparam int unsigned IDX_W = $clog2(NCH);

    typedef struct {
        logic [CNT_W-1:0]  cnt [NCH];
        logic [CNT_W-1:0]  mat [NCH];
        logic [CTL_W-1:0]  ctl [NCH];
        logic [NCH-1:0]    armed;
        logic [NCH-1:0]    stat;
        logic [NCH-1:0]    ena;
        logic [CNT_W-1:0]  snap;
        logic [DATA_W-1:0] rdata;
    } state_t;

    state_t q, d;

    // ---------------- address decode ----------------
    logic [7:0]       a8;
    logic [IDX_W-1:0] slot;
    logic [NCH-1:0]   cnt_wr, mat_wr, ctl_wr, cnt_rd;
    logic             stat_wr, ena_wr;

    assign a8   = addr_i[7:0];
    assign slot = a8[4:2];

    always_comb begin
        cnt_wr = '0;
        mat_wr = '0;
        ctl_wr = '0;
        cnt_rd = '0;
        if (a8[7:5] == RG_CNT) begin
            cnt_wr[slot] = wr_en_i;
            cnt_rd[slot] = rd_en_i;
        end
        if (a8[7:5] == RG_MAT) mat_wr[slot] = wr_en_i;
        if (a8[7:5] == RG_CTL) ctl_wr[slot] = wr_en_i;
        stat_wr = wr_en_i && (a8 == A_STAT);
        ena_wr  = wr_en_i && (a8 == A_ENA);
    end

    // ---------------- per-channel tick and match ----------------
    logic [2:0]     lead [NCH];
    logic [NCH-1:0] own_src, step, hit;

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        assign lead[g]    = lead_of(3'(g), q.ctl[g][CB_OWN]);
        assign own_src[g] = (lead[g] == 3'(g));

        // A follower's own counter never runs; bit 8 only survives in wide words.
        ext_tmr_tick_mux u_mux (
            .sel_i  (q.ctl[g][2:0]),
            .halt_i (!own_src[g] || q.ctl[g][CB_HALT]),
            .tick_i (tick_i),
            .step_o (step[g])
        );

        ext_tmr_cmp #(.CNT_W(CNT_W)) u_cmp (
            .armed_i (q.armed[g]),
            .step_i  (step[lead[g]]),
            .cnt_i   (q.cnt[lead[g]]),
            .mat_i   (q.mat[g]),
            .hit_o   (hit[g])
        );

        assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (!step[g] && !cnt_wr[g]) |=> $stable(q.cnt[g]))
            else $error("counter moved without tick or write");

        assert_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (hit[g] && step[g] && q.ctl[g][CB_ZERO] && !cnt_wr[g]) |=> (q.cnt[g] == '0))
            else $error("zero-on-match did not clear counter");

        assert_once_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (hit[g] && !q.ctl[g][CB_REPEAT] && !mat_wr[g] && !ctl_wr[g]) |=> !q.armed[g])
            else $error("one-shot channel still armed");

        assert_load_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
            cnt_wr[g] |=> (q.cnt[g] == $past(wdata_i[CNT_W-1:0])))
            else $error("counter write lost");
    end

    // ---------------- read mux ----------------
    logic [DATA_W-1:0] rd_val;

    always_comb begin
        rd_val = '0;
        unique case (a8[7:5])
            RG_CNT:  rd_val = DATA_W'(q.cnt[slot]);
            RG_MAT:  rd_val = DATA_W'(q.mat[slot]);
            RG_CTL:  rd_val = DATA_W'(q.ctl[slot]);
            default: begin
                if (a8 == A_STAT) rd_val = DATA_W'(q.stat) << FIRST_CH;
                if (a8 == A_ENA)  rd_val = DATA_W'(q.ena) << FIRST_CH;
                if (a8 == A_SNAP) rd_val = DATA_W'(q.snap);
            end
        endcase
    end

    // ---------------- next state ----------------
    logic [NCH-1:0] clr_mask;
    assign clr_mask = stat_wr ? wdata_i[FIRST_CH +: NCH] : '0;

    always_comb begin
        d = q;
        for (int i = 0; i < NCH; i++) begin
            if (step[i]) begin
                d.cnt[i] = (hit[i] && q.ctl[i][CB_ZERO]) ? '0 : q.cnt[i] + 1'b1;
            end
            if (hit[i] && !q.ctl[i][CB_REPEAT]) d.armed[i] = 1'b0;
            if (cnt_wr[i]) d.cnt[i] = wdata_i[CNT_W-1:0];
            if (mat_wr[i]) begin
                d.mat[i]   = wdata_i[CNT_W-1:0];
                d.armed[i] = 1'b1;
            end
            if (ctl_wr[i]) begin
                if (i < WIDE_BASE) d.ctl[i] = {{(CTL_W-NARROW_W){1'b0}}, wdata_i[NARROW_W-1:0]};
                else               d.ctl[i] = wdata_i[CTL_W-1:0];
                d.armed[i] = 1'b1;
            end
            // odd wide channels may freeze their even neighbour on a counter read
            if (i >= WIDE_BASE && (i % 2) == 1 && cnt_rd[i] && q.ctl[i][CB_SNAP]) begin
                d.snap = q.cnt[i-1];
            end
        end
        d.stat = (q.stat & ~clr_mask) | (hit & q.ena);
        if (ena_wr)  d.ena   = wdata_i[FIRST_CH +: NCH];
        if (rd_en_i) d.rdata = rd_val;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            for (int i = 0; i < NCH; i++) begin
                q.cnt[i] <= '0;
                q.mat[i] <= '0;
                q.ctl[i] <= '0;
            end
            q.armed <= '0;
            q.stat  <= '0;
            q.ena   <= '0;
            q.snap  <= '0;
            q.rdata <= '0;
        end else begin
            q <= d;
        end
    end

    assign rdata_o = q.rdata;
    assign irq_o   = |q.stat;

    assert_snap_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(q.snap) |-> $past(rd_en_i))
        else $error("snapshot changed without a read");

    assert_irq_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(irq_o) |-> $past(stat_wr))
        else $error("interrupt fell without a status clear");
endmodule

// File: tb/ext_timer_bank_test.sv
module ext_timer_bank_test;
    localparam int unsigned PERIOD = 8;
    localparam logic [1:0] OP_WR = 2'd0;
    localparam logic [1:0] OP_RD = 2'd1;
    localparam logic [1:0] OP_TK = 2'd2;

    typedef struct packed {
        logic [1:0]  op;
        logic [7:0]  addr;
        logic [31:0] data;   // write data, expected read data, or tick pattern
        logic [3:0]  req;
    } vec_t;

    localparam int NVEC = 29;
    localparam vec_t VEC [NVEC] = '{
        '{OP_WR, 8'hC0, 32'h004, 4'd2},   // ch4 own, 1 MHz tick (R2)
        '{OP_WR, 8'h80, 32'h003, 4'd4},
        '{OP_WR, 8'h1C, 32'hFF0, 4'd9},
        '{OP_TK, 8'h00, 32'h008, 4'd2},
        '{OP_TK, 8'h00, 32'h001, 4'd2},   // unselected tick ignored
        '{OP_RD, 8'h40, 32'h001, 4'd2},   // R2, R12
        '{OP_TK, 8'h00, 32'h008, 4'd4},
        '{OP_TK, 8'h00, 32'h008, 4'd4},   // ch4 reaches 3
        '{OP_RD, 8'h14, 32'h010, 4'd4},   // R4
        '{OP_WR, 8'h14, 32'h010, 4'd9},
        '{OP_RD, 8'h14, 32'h000, 4'd9},   // R9 write-one clear
        '{OP_WR, 8'hC4, 32'h000, 4'd3},   // ch5 follows ch4
        '{OP_WR, 8'h84, 32'h005, 4'd3},
        '{OP_TK, 8'h00, 32'h008, 4'd3},
        '{OP_TK, 8'h00, 32'h008, 4'd3},
        '{OP_RD, 8'h14, 32'h020, 4'd3},   // R3 follower matched on shared count
        '{OP_RD, 8'h44, 32'h000, 4'd3},   // R3 follower's own counter idle
        '{OP_WR, 8'h14, 32'h020, 4'd9},
        '{OP_WR, 8'hD0, 32'h04C, 4'd5},   // ch8: zero-on-match, periodic
        '{OP_WR, 8'h90, 32'h002, 4'd5},
        '{OP_TK, 8'h00, 32'h008, 4'd5},
        '{OP_TK, 8'h00, 32'h008, 4'd5},
        '{OP_RD, 8'h50, 32'h000, 4'd5},   // R5
        '{OP_TK, 8'h00, 32'h008, 4'd6},
        '{OP_TK, 8'h00, 32'h008, 4'd6},
        '{OP_RD, 8'h14, 32'h100, 4'd6},   // R6 periodic matched again
        '{OP_RD, 8'h40, 32'h009, 4'd12},  // R12 ch4 counted all 1 MHz pulses
        '{OP_WR, 8'h14, 32'hFF0, 4'd9},
        '{OP_RD, 8'h14, 32'h000, 4'd9}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [4:0]  tick = '0;
    logic [31:0] rdata;
    logic        irq;
    int          checks = 0, fails = 0;
    bit          done = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    ext_timer_bank uut (
        .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
        .addr_i(addr), .wdata_i(wdata), .tick_i(tick),
        .rdata_o(rdata), .irq_o(irq)
    );

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // inputs change just after a falling edge; results are sampled at the next one
    task automatic bus(input logic w, input logic r, input logic [7:0] a,
                       input logic [31:0] dat, input logic [4:0] tk);
        wr_en = w; rd_en = r; addr = a; wdata = dat; tick = tk;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0; tick = '0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] dat);
        bus(1'b1, 1'b0, a, dat, 5'd0);
    endtask

    task automatic tk(input logic [4:0] pat);
        bus(1'b0, 1'b0, 8'h00, 32'h0, pat);
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string tag);
        bus(1'b0, 1'b1, a, 32'h0, 5'd0);
        check(rdata, exp, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check({31'h0, irq}, 32'h0, "R1 irq");
        check(rdata, 32'h0, "R1 rdata");
        rd_chk(8'h40, 32'h0, "R1 counter");
        rd_chk(8'h14, 32'h0, "R1 status");
        rd_chk(8'h1C, 32'h0, "R1 enable");
        rd_chk(8'hDC, 32'h0, "R1 control");
        rd_chk(8'h20, 32'h0, "R1 snapshot");

        for (int i = 0; i < NVEC; i++) begin
            case (VEC[i].op)
                OP_WR: wr(VEC[i].addr, VEC[i].data);
                OP_TK: tk(VEC[i].data[4:0]);
                default: rd_chk(VEC[i].addr, VEC[i].data,
                                $sformatf("R%0d vector %0d", VEC[i].req, i));
            endcase
        end

        // R10 combined interrupt: ch4 count is 9, ch8 count is 0
        wr(8'h80, 32'hA);
        tk(5'h08);
        check({31'h0, irq}, 32'h1, "R10 irq on first match");
        tk(5'h08);
        rd_chk(8'h14, 32'h110, "R10 two status bits");
        wr(8'h14, 32'h010);
        check({31'h0, irq}, 32'h1, "R10 irq held by remaining bit");
        wr(8'h14, 32'h100);
        check({31'h0, irq}, 32'h0, "R10 irq dropped");

        // R9 enable gating: only ch4 enabled, ch8 matches again
        wr(8'h1C, 32'h010);
        tk(5'h08);
        tk(5'h08);
        rd_chk(8'h14, 32'h0, "R9 disabled match sets no status");
        check({31'h0, irq}, 32'h0, "R9 irq stays low");
        rd_chk(8'h1C, 32'h010, "R9 enable readback");

        // R11 write beats tick in the same cycle
        bus(1'b1, 1'b0, 8'h50, 32'h77, 5'h08);
        rd_chk(8'h50, 32'h77, "R11 write priority");

        // R7 halt bit and control widths
        wr(8'hD0, 32'h14C);
        tk(5'h08);
        rd_chk(8'h50, 32'h77, "R7 halted counter held");
        wr(8'h50, 32'h5);
        rd_chk(8'h50, 32'h5, "R11 write while stopped");
        rd_chk(8'hD0, 32'h14C, "R7 wide control readback");
        wr(8'hC4, 32'hFFF);
        rd_chk(8'hC4, 32'hFF, "R7 narrow control mask");
        wr(8'hD4, 32'hFFF);
        rd_chk(8'hD4, 32'h3FF, "R7 wide control mask");

        // R8 snapshot on read of ch9 counter
        rd_chk(8'h54, 32'h0, "R8 ch9 own counter");
        rd_chk(8'h20, 32'h5, "R8 snapshot of ch8");
        wr(8'hD4, 32'h000);
        wr(8'h50, 32'h33);
        rd_chk(8'h54, 32'h0, "R8 ch9 read without capture");
        rd_chk(8'h20, 32'h5, "R8 snapshot unchanged");

        // R3 own counter with bit 7; R2 external tick selection
        wr(8'hC4, 32'h84);
        wr(8'h44, 32'h0);
        tk(5'h08);
        tk(5'h08);
        tk(5'h08);
        rd_chk(8'h44, 32'h3, "R3 private counter runs");
        rd_chk(8'h40, 32'h12, "R3 leader independent");
        wr(8'hC8, 32'h85);
        tk(5'h10);
        rd_chk(8'h48, 32'h1, "R2 external tick");
        rd_chk(8'h40, 32'h12, "R2 other rate unaffected");

        // R5 with R6 one-shot on ch4
        wr(8'hC0, 32'h0C);
        wr(8'h80, 32'h2);
        wr(8'h40, 32'h0);
        tk(5'h08);
        tk(5'h08);
        rd_chk(8'h40, 32'h0, "R5 cleared on match");
        rd_chk(8'h14, 32'h010, "R4 match status");
        wr(8'h14, 32'h010);
        tk(5'h08);
        tk(5'h08);
        rd_chk(8'h14, 32'h0, "R6 one-shot no second match");
        rd_chk(8'h40, 32'h2, "R6 counter passed match value");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule